// File: doc/BRIEF.md
# Debug Session State Sequencer

This block follows an on-chip debug session. Software arms the session through a control register. A numbered sequence of states then advances, one step per comparator match, until a final state is reached. That final state asks the CPU for a breakpoint for one cycle and then closes the session. Two sticky status flags record that the trace buffer has filled and that an external tag hit was seen. Software reads both flags together with the current state code from a read-only status byte.

The block has two reset inputs. A power-on reset clears everything. A system reset clears the session, but the trace-full flag keeps its value, so a debugger can still tell after a crash that the whole buffer holds valid lines. The trace memory, the address comparators and the CPU's handling of the breakpoint lie outside this block.

Top module: `dbg_session_seq`

## Requirements
- R1: After power-on reset, the status byte reads 0x00, the control byte reads 0x00 and `brk_req` is low.
- R2: A write of 1 to the arm bit (control address 0, bit 0) sets the state field (status bits 2:0) to 001 and the control readback to 0x01 from the next cycle on.
- R3: When armed, state 001 goes to 010 on `cmp_hit[0]`, 010 goes to 011 on `cmp_hit[1]`, and 011 goes to the final code 100 on `cmp_hit[2]`. The state moves at most one step per cycle, and the match bits that do not belong to the current state are ignored.
- R4: `brk_req` is high for exactly the one cycle in which the state reads 100. In the following cycle the state reads 000 and the arm bit reads 0.
- R5: A write of 0 to the arm bit disarms the session, and the state field keeps the last code it reached.
- R6: While disarmed, comparator matches, tag hits and trace strobes change neither the status byte nor `brk_req`.
- R7: The tag flag (status bit 6) sets in the cycle after `ext_tag_hit` is seen while armed. It stays set until the next arm write.
- R8: The trace-full flag (status bit 7) sets once the 64th `trace_stored` strobe since arming has been counted while armed. It stays set through further strobes, and an arm write clears it.
- R9: A system reset clears the arm bit, the state, the tag flag and `brk_req`, and leaves the trace-full flag unchanged. A power-on reset clears the trace-full flag too.
- R10: A write to the status address (1) has no effect, and status bits 5:3 always read 0.
- R11: An arm write takes priority over a comparator match, a tag hit or a trace strobe in the same cycle. The result is state 001 with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| cmp_hit | input | 3 | Comparator match inputs, bit k advances state k+1 |
| ext_tag_hit | input | 1 | External tag hit |
| trace_stored | input | 1 | One trace line stored this cycle |
| brk_req | output | 1 | Breakpoint request pulse |

## Verification
An arm write can land in the same cycle as a comparator match, a tag hit and a trace strobe. Without the priority rule, a flag could end up set, or the state could read 010. The bench provokes this by asserting all four together while the tag flag is already set. It then expects the status byte to read exactly 0x01 and the control byte to read 0x01 after that edge.

// File: rtl/dbg_seq_pkg.sv
`timescale 1ns/1ps
package dbg_seq_pkg;
    localparam int STATE_W = 3;
    localparam logic [STATE_W-1:0] ST_OFF = 3'b000;
    localparam logic [STATE_W-1:0] ST_ONE = 3'b001;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;
    localparam int   ARM_BIT     = 0;

    typedef struct packed {
        logic               armed;
        logic [STATE_W-1:0] state;
        logic               brk;
    } seq_regs_t;
endpackage

// File: rtl/dbg_seq_fsm.sv
`timescale 1ns/1ps
module dbg_seq_fsm
    import dbg_seq_pkg::*;
#(
    parameter int NUM_STEPS = 3
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rst_n,
    input  logic                 arm_set,
    input  logic                 arm_clr,
    input  logic [NUM_STEPS-1:0] cmp_hit,
    output logic                 armed,
    output logic [STATE_W-1:0]   state,
    output logic                 brk_req
);
    localparam logic [STATE_W-1:0] ST_FINAL = STATE_W'(NUM_STEPS + 1);

    seq_regs_t seq_d, seq_q;
    logic      step_hit;

    always_comb begin
        step_hit = 1'b0;
        for (int k = 0; k < NUM_STEPS; k++) begin
            if (seq_q.state == STATE_W'(k + 1)) step_hit = cmp_hit[k];
        end
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.brk = 1'b0;
        if (!sys_rst_n) begin
            seq_d = '0;
        end else if (arm_set) begin
            seq_d.armed = 1'b1;
            seq_d.state = ST_ONE;
        end else if (seq_q.armed && seq_q.state == ST_FINAL) begin
            seq_d.armed = 1'b0;
            seq_d.state = ST_OFF;
        end else if (arm_clr) begin
            seq_d.armed = 1'b0;
        end else if (seq_q.armed && step_hit) begin
            seq_d.state = seq_q.state + STATE_W'(1);
            seq_d.brk   = (seq_q.state == STATE_W'(NUM_STEPS));
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign armed   = seq_q.armed;
    assign state   = seq_q.state;
    assign brk_req = seq_q.brk;

    assert_arm_enter_R2: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && arm_set) |=> (armed && state == ST_ONE));

    assert_one_step_R3: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && !arm_clr && armed && state != ST_FINAL)
        |=> (state == $past(state) || state == $past(state) + STATE_W'(1)));

    assert_brk_single_R4: assert property (@(posedge clk) disable iff (!por_n)
        brk_req |=> !brk_req);

    assert_final_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && armed && state == ST_FINAL)
        |=> (!armed && state == ST_OFF));

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && arm_clr && armed && state != ST_FINAL)
        |=> (!armed && state == $past(state)));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && !armed) |=> (!armed && $stable(state) && !brk_req));
endmodule

// File: rtl/dbg_trace_fill.sv
`timescale 1ns/1ps
module dbg_trace_fill #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic clr,
    input  logic line_en,
    output logic full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
    } fill_regs_t;

    fill_regs_t fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (clr) begin
            fill_d = '0;
        end else if (!sys_rst_n) begin
            fill_d.cnt = '0;
        end else if (line_en && fill_q.cnt != LIMIT) begin
            fill_d.cnt = fill_q.cnt + CNT_W'(1);
            if (fill_q.cnt == LIMIT - CNT_W'(1)) fill_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign full = fill_q.full;

    assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!por_n)
        (fill_q.cnt == LIMIT && sys_rst_n && !clr) |=> fill_q.cnt == LIMIT);

    assert_limit_full_R8: assert property (@(posedge clk) disable iff (!por_n)
        (fill_q.cnt == LIMIT) |-> full);

    assert_full_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        (full && !clr) |=> full);
endmodule

// File: rtl/dbg_session_seq.sv
`timescale 1ns/1ps
module dbg_session_seq
    import dbg_seq_pkg::*;
#(
    parameter int NUM_STEPS   = 3,
    parameter int TRACE_DEPTH = 64
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_STEPS-1:0] cmp_hit,
    input  logic                 ext_tag_hit,
    input  logic                 trace_stored,
    output logic                 brk_req
);
    localparam int PAD_W = 8 - 2 - STATE_W;

    logic               ctrl_wr, arm_set, arm_clr;
    logic               armed, trace_full;
    logic [STATE_W-1:0] state;
    logic               tag_d, tag_q;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign arm_set = ctrl_wr &&  reg_wdata[ARM_BIT];
    assign arm_clr = ctrl_wr && !reg_wdata[ARM_BIT];

    dbg_seq_fsm #(.NUM_STEPS(NUM_STEPS)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .arm_set   (arm_set),
        .arm_clr   (arm_clr),
        .cmp_hit   (cmp_hit),
        .armed     (armed),
        .state     (state),
        .brk_req   (brk_req)
    );

    dbg_trace_fill #(.DEPTH(TRACE_DEPTH)) u_fill (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .clr       (arm_set),
        .line_en   (armed && trace_stored),
        .full      (trace_full)
    );

    always_comb begin
        tag_d = tag_q;
        if (!sys_rst_n)                tag_d = 1'b0;
        else if (arm_set)              tag_d = 1'b0;
        else if (armed && ext_tag_hit) tag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) tag_q <= 1'b0;
        else        tag_q <= tag_d;
    end

    always_comb begin
        if (reg_addr == ADDR_STATUS) reg_rdata = {trace_full, tag_q, {PAD_W{1'b0}}, state};
        else                         reg_rdata = {7'b0, armed};
    end

    assert_tag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && tag_q) |=> tag_q);

    assert_tag_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && !arm_set && !armed) |=> $stable(tag_q));

    assert_arm_clears_R11: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && arm_set) |=> (!tag_q && !trace_full));
endmodule

// File: tb/sim_dbg_session_seq.sv
`timescale 1ns/1ps
module sim_dbg_session_seq;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b1;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] cmp_hit = 3'b000;
    logic       ext_tag_hit = 1'b0;
    logic       trace_stored = 1'b0;
    logic       brk_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_session_seq u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_hit(cmp_hit), .ext_tag_hit(ext_tag_hit),
        .trace_stored(trace_stored), .brk_req(brk_req)
    );

    // {req[3:0], wr, addr, wdata[7:0], cmp[2:0], tag, strobe, exp_status[7:0], exp_brk}
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {4'd2,  1'b1, 1'b0, 8'h01, 3'b000, 1'b0, 1'b0, 8'h01, 1'b0}, // R2 arm
        {4'd3,  1'b0, 1'b0, 8'h00, 3'b110, 1'b0, 1'b0, 8'h01, 1'b0}, // R3 wrong bits ignored
        {4'd3,  1'b0, 1'b0, 8'h00, 3'b001, 1'b0, 1'b0, 8'h02, 1'b0}, // R3 A step
        {4'd3,  1'b0, 1'b0, 8'h00, 3'b101, 1'b0, 1'b0, 8'h02, 1'b0}, // R3 no B
        {4'd7,  1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h42, 1'b0}, // R7 tag sets
        {4'd3,  1'b0, 1'b0, 8'h00, 3'b010, 1'b0, 1'b0, 8'h43, 1'b0}, // R3 B step
        {4'd4,  1'b0, 1'b0, 8'h00, 3'b100, 1'b0, 1'b0, 8'h44, 1'b1}, // R4 final, brk
        {4'd4,  1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 8'h40, 1'b0}, // R4 back to 000
        {4'd6,  1'b0, 1'b0, 8'h00, 3'b111, 1'b1, 1'b1, 8'h40, 1'b0}, // R6 disarmed
        {4'd2,  1'b1, 1'b0, 8'h01, 3'b000, 1'b0, 1'b0, 8'h01, 1'b0}, // R2 re-arm clears tag
        {4'd3,  1'b0, 1'b0, 8'h00, 3'b001, 1'b0, 1'b0, 8'h02, 1'b0}, // R3
        {4'd5,  1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 8'h02, 1'b0}, // R5 disarm freezes
        {4'd6,  1'b0, 1'b0, 8'h00, 3'b111, 1'b1, 1'b1, 8'h02, 1'b0}, // R6
        {4'd10, 1'b1, 1'b1, 8'hFF, 3'b000, 1'b0, 1'b0, 8'h02, 1'b0}  // R10 status write
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic read_chk(input int req, input logic addr, input logic [7:0] exp);
        reg_addr = addr;
        #1;
        check(req, reg_rdata, exp);
        reg_addr = 1'b1;
    endtask

    // one clock with the given stimulus; inputs return to idle 2 ns after the edge
    task automatic step(input logic wr, input logic addr, input logic [7:0] wd,
                        input logic [2:0] cmp, input logic tag, input logic str);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        cmp_hit = cmp; ext_tag_hit = tag; trace_stored = str;
        @(posedge clk);
        #2;
        reg_wr = 1'b0; reg_addr = 1'b1; reg_wdata = 8'h00;
        cmp_hit = 3'b000; ext_tag_hit = 1'b0; trace_stored = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #35;
        read_chk(1, 1'b1, 8'h00);              // R1 during reset
        @(negedge clk); por_n = 1'b1;
        @(posedge clk); #2;
        read_chk(1, 1'b1, 8'h00);              // R1 status
        read_chk(1, 1'b0, 8'h00);              // R1 control
        check(1, {7'b0, brk_req}, 8'h00);      // R1 brk_req

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23], VEC[i][22], VEC[i][21:14], VEC[i][13:11],
                 VEC[i][10], VEC[i][9]);
            read_chk(int'(VEC[i][27:24]), 1'b1, VEC[i][8:1]);
            check(int'(VEC[i][27:24]), {7'b0, brk_req}, {7'b0, VEC[i][0]});
        end
        read_chk(5, 1'b0, 8'h00);              // R5 arm bit reads 0

        // R8: trace-full after 64 strobes, saturation
        step(1'b1, 1'b0, 8'h01, 3'b000, 1'b0, 1'b0);
        read_chk(2, 1'b0, 8'h01);              // R2 control readback
        for (int i = 0; i < 63; i++) step(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        read_chk(8, 1'b1, 8'h01);              // R8 not yet full at 63
        step(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        read_chk(8, 1'b1, 8'h81);              // R8 full at 64
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        read_chk(8, 1'b1, 8'h81);              // R8 stays full

        // R9: system reset keeps trace-full
        step(1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        read_chk(7, 1'b1, 8'hC1);              // R7 tag with full
        @(negedge clk); sys_rst_n = 1'b0;
        @(posedge clk); #2; sys_rst_n = 1'b1;
        read_chk(9, 1'b1, 8'h80);              // R9 full survives
        read_chk(9, 1'b0, 8'h00);              // R9 disarmed
        check(9, {7'b0, brk_req}, 8'h00);

        // R8: arm write clears trace-full
        step(1'b1, 1'b0, 8'h01, 3'b000, 1'b0, 1'b0);
        read_chk(8, 1'b1, 8'h01);

        // R11: arm write together with match, tag and strobe
        step(1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        read_chk(11, 1'b1, 8'h41);
        step(1'b1, 1'b0, 8'h01, 3'b001, 1'b1, 1'b1);
        read_chk(11, 1'b1, 8'h01);
        read_chk(11, 1'b0, 8'h01);

        // R9: power-on reset clears trace-full
        step(1'b1, 1'b0, 8'h01, 3'b000, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) step(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        read_chk(9, 1'b1, 8'h81);
        @(negedge clk); por_n = 1'b0;
        #3;
        read_chk(9, 1'b1, 8'h00);
        @(negedge clk); por_n = 1'b1;
        @(posedge clk); #2;
        read_chk(9, 1'b1, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule